// File: doc/BRIEF.md
# Display Row Phase Timing Generator

This block paces the row scan of a multiplexed passive-matrix display driver. It divides the operating clock into a display tick. It splits every row period into three phases, in this order: discharge of the column lines, precharge towards the target level, and current drive. It walks a row counter from 0 up to a programmable last row. When the counter wraps back to 0 it raises a one-cycle frame-start pulse. Display-refresh logic uses the phase indicators to switch the column drivers and uses the row index to pick the active common line.

The division ratio, the three phase lengths and the last-row value are plain inputs. The block captures them into shadow registers in the last cycle of every row, so each new setting takes effect from the following row. Every phase therefore lasts a whole number of ticks, even when software changes a setting in the middle of a row. One row lasts (discharge + precharge + drive) ticks. One frame lasts that many ticks multiplied by (last row + 1).

The controlling state machine has four states:
- `ST_IDLE`: the display is off.
- `ST_DISCHG`, `ST_PRECHG`, `ST_DRIVE`: the three phases of a row.

Its transitions are:
- Enable: `ST_IDLE` to `ST_DISCHG` when `disp_on` is high.
- Discharge done: `ST_DISCHG` to `ST_PRECHG` on the tick that completes the discharge length.
- Precharge done: `ST_PRECHG` to `ST_DRIVE` on the tick that completes the precharge length.
- Row end: `ST_DRIVE` to `ST_DISCHG` on the tick that completes the drive length.
- Shutdown: any phase state to `ST_IDLE` when `disp_on` is low.

Top module: `dtg_row_timing`

## Requirements
- R1: After reset, all three phase indicators, `disp_tick`, `frame_start` and `row_idx` are 0. The shadow settings start at a division code of 0 (D = 1), lengths of 2, 2 and 65, and a last row of 63.
- R2: While a row is being scanned, `disp_tick` is high for one operating clock in every D clocks, where D = `div_code` + 1 (1 to 16). While the display is off, `disp_tick` stays 0.
- R3: While scanning, exactly one phase indicator is high. The phases follow each other as discharge, precharge, drive and then discharge of the next row.
- R4: A phase of length L lasts L x D operating clocks, so a row spans exactly (L1+L2+L3) ticks. The length fields are 4 bits for discharge, 4 bits for precharge and 8 bits for drive.
- R5: A length field of 0 acts as a length of 1 tick, so the sequence never stalls.
- R6: `row_idx` changes only at a row end, where it steps up by 1. A row end at a row index greater than or equal to the 6-bit last-row value sends `row_idx` back to 0, so a frame has (last row + 1) rows.
- R7: `frame_start` is high for exactly the first operating clock of a row that began through a wrap to row 0. It is never high at any other time, including the first row after enabling.
- R8: The inputs `div_code`, `dis_len`, `pre_len`, `drv_len` and `mux_last` are captured only in the last clock of a row. They govern the row that follows. The first row after enabling uses the values captured at the latest earlier row end, or the reset values of R1 if there was none.
- R9: When `disp_on` is sampled low, the next clock shows all phase indicators at 0 and `row_idx` at 0. When `disp_on` is sampled high from off, the next clock starts a discharge phase at row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_on | input | 1 | Display enable |
| div_code | input | 4 | Clock division code; D = code + 1 |
| dis_len | input | 4 | Discharge length in ticks |
| pre_len | input | 4 | Precharge length in ticks |
| drv_len | input | 8 | Current-drive length in ticks |
| mux_last | input | 6 | Index of the last row in a frame |
| disp_tick | output | 1 | Display clock enable pulse |
| ph_discharge | output | 1 | Discharge phase active |
| ph_precharge | output | 1 | Precharge phase active |
| ph_drive | output | 1 | Current-drive phase active |
| row_idx | output | 6 | Row currently scanned |
| frame_start | output | 1 | One-cycle pulse at the start of a new frame |

## Verification
The first run after reset enables the block with non-default inputs. Its first row must still take the reset lengths at D = 1, which shows that the reset defaults are in effect and that the inputs are taken up only at a row boundary. Later runs separate the effect of the divider from that of the phase lengths:
- Zero lengths with a single-row frame show the clamping to 1 tick. They also show a frame pulse on every row.
- A division of 16 with short lengths shows that every phase stretches by D.
- Maximum lengths with a two-row frame check the wide drive counter and the alternating wrap.

Each run is switched off in the middle of a row. This checks the shutdown state and that a cut-off row leaves the shadow settings unchanged for the next run.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DISCHG = 2'd1,
        ST_PRECHG = 2'd2,
        ST_DRIVE  = 2'd3
    } dtg_state_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dtg_clk_div.sv
module dtg_clk_div #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    // ">=" keeps the counter bounded if the code shrinks between rows
    assign at_end = (cnt_q >= div_code);
    assign tick   = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dtg_cfg_latch.sv
module dtg_cfg_latch #(
    parameter int unsigned W          = 4,
    parameter int unsigned RST_VAL    = 0,
    parameter bit          CLAMP_ZERO = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] d_eff;

    generate
        if (CLAMP_ZERO) begin : g_clamp
            assign d_eff = (din == '0) ? W'(1) : din;
        end else begin : g_pass
            assign d_eff = din;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= W'(RST_VAL);
        end else if (load) begin
            q <= d_eff;
        end
    end

endmodule

// File: rtl/dtg_row_ctr.sv
module dtg_row_ctr #(
    parameter int unsigned ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic [ROW_W-1:0] last_row,
    output logic [ROW_W-1:0] row,
    output logic             wrap_pulse
);

    logic wrap_now;

    assign wrap_now = (row >= last_row);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row        <= '0;
            wrap_pulse <= 1'b0;
        end else if (clear) begin
            row        <= '0;
            wrap_pulse <= 1'b0;
        end else if (adv) begin
            row        <= wrap_now ? '0 : row + 1'b1;
            wrap_pulse <= wrap_now;
        end else begin
            wrap_pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/dtg_row_timing.sv
module dtg_row_timing
    import dtg_pkg::*;
#(
    parameter int unsigned DIV_W    = 4,
    parameter int unsigned P1_W     = 4,
    parameter int unsigned P2_W     = 4,
    parameter int unsigned P3_W     = 8,
    parameter int unsigned ROW_W    = 6,
    parameter int unsigned DIV_DEF  = 0,
    parameter int unsigned P1_DEF   = 2,
    parameter int unsigned P2_DEF   = 2,
    parameter int unsigned P3_DEF   = 65,
    parameter int unsigned MUX_DEF  = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_on,
    input  logic [DIV_W-1:0] div_code,
    input  logic [P1_W-1:0]  dis_len,
    input  logic [P2_W-1:0]  pre_len,
    input  logic [P3_W-1:0]  drv_len,
    input  logic [ROW_W-1:0] mux_last,
    output logic             disp_tick,
    output logic             ph_discharge,
    output logic             ph_precharge,
    output logic             ph_drive,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_start
);

    localparam int unsigned PC_W = max3(P1_W, P2_W, P3_W);

    dtg_state_e       state_q, state_d;
    logic [PC_W-1:0]  pcnt_q;
    logic [PC_W-1:0]  cur_len;
    logic             phase_last;
    logic             running;
    logic             tick;
    logic             row_end;

    logic [DIV_W-1:0] div_sh;
    logic [P1_W-1:0]  p1_sh;
    logic [P2_W-1:0]  p2_sh;
    logic [P3_W-1:0]  p3_sh;
    logic [ROW_W-1:0] mux_sh;

    assign running = (state_q != ST_IDLE);

    // ---------------- display clock enable ----------------
    dtg_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .div_code (div_sh),
        .tick     (tick)
    );

    // ---------------- shadow settings, taken at row end ----------------
    dtg_cfg_latch #(.W(DIV_W), .RST_VAL(DIV_DEF), .CLAMP_ZERO(1'b0)) u_sh_div (
        .clk(clk), .rst_n(rst_n), .load(row_end), .din(div_code), .q(div_sh)
    );
    dtg_cfg_latch #(.W(P1_W), .RST_VAL(P1_DEF), .CLAMP_ZERO(1'b1)) u_sh_p1 (
        .clk(clk), .rst_n(rst_n), .load(row_end), .din(dis_len), .q(p1_sh)
    );
    dtg_cfg_latch #(.W(P2_W), .RST_VAL(P2_DEF), .CLAMP_ZERO(1'b1)) u_sh_p2 (
        .clk(clk), .rst_n(rst_n), .load(row_end), .din(pre_len), .q(p2_sh)
    );
    dtg_cfg_latch #(.W(P3_W), .RST_VAL(P3_DEF), .CLAMP_ZERO(1'b1)) u_sh_p3 (
        .clk(clk), .rst_n(rst_n), .load(row_end), .din(drv_len), .q(p3_sh)
    );
    dtg_cfg_latch #(.W(ROW_W), .RST_VAL(MUX_DEF), .CLAMP_ZERO(1'b0)) u_sh_mux (
        .clk(clk), .rst_n(rst_n), .load(row_end), .din(mux_last), .q(mux_sh)
    );

    // ---------------- phase length select ----------------
    always_comb begin
        cur_len = PC_W'(1);
        unique case (state_q)
            ST_IDLE:   cur_len = PC_W'(1);
            ST_DISCHG: cur_len = PC_W'(p1_sh);
            ST_PRECHG: cur_len = PC_W'(p2_sh);
            ST_DRIVE:  cur_len = PC_W'(p3_sh);
        endcase
    end

    assign phase_last = (pcnt_q == cur_len - 1'b1);
    assign row_end    = disp_on && (state_q == ST_DRIVE) && tick && phase_last;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (disp_on) state_d = ST_DISCHG;
            end
            ST_DISCHG: begin
                if (!disp_on)               state_d = ST_IDLE;
                else if (tick && phase_last) state_d = ST_PRECHG;
            end
            ST_PRECHG: begin
                if (!disp_on)               state_d = ST_IDLE;
                else if (tick && phase_last) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (!disp_on)               state_d = ST_IDLE;
                else if (tick && phase_last) state_d = ST_DISCHG;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- tick counter within a phase ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!disp_on || !running) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= phase_last ? '0 : pcnt_q + 1'b1;
        end
    end

    // ---------------- row counter and frame pulse ----------------
    dtg_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!disp_on),
        .adv        (row_end),
        .last_row   (mux_sh),
        .row        (row_idx),
        .wrap_pulse (frame_start)
    );

    // ---------------- outputs from state ----------------
    always_comb begin
        ph_discharge = 1'b0;
        ph_precharge = 1'b0;
        ph_drive     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_DISCHG: ph_discharge = 1'b1;
            ST_PRECHG: ph_precharge = 1'b1;
            ST_DRIVE:  ph_drive     = 1'b1;
        endcase
    end

    assign disp_tick = tick;

endmodule

// File: rtl/dtg_row_timing_chk.sv
module dtg_row_timing_chk #(
    parameter int unsigned ROW_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_on,
    input logic             disp_tick,
    input logic             ph_discharge,
    input logic             ph_precharge,
    input logic             ph_drive,
    input logic [ROW_W-1:0] row_idx,
    input logic             frame_start
);

    assert_onehot_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ph_discharge, ph_precharge, ph_drive}));

    assert_prech_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_precharge) |-> $past(ph_discharge && disp_tick));

    assert_drive_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_drive) |-> $past(ph_precharge && disp_tick));

    assert_tick_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_discharge || ph_precharge || ph_drive) |-> !disp_tick);

    assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on && $past(disp_on) && !$stable(row_idx)) |-> $past(ph_drive && disp_tick));

    assert_frame_row0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (row_idx == '0) && ph_discharge);

    assert_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> !(ph_discharge || ph_precharge || ph_drive) && (row_idx == '0));

endmodule

bind dtg_row_timing dtg_row_timing_chk #(.ROW_W(ROW_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_on      (disp_on),
    .disp_tick    (disp_tick),
    .ph_discharge (ph_discharge),
    .ph_precharge (ph_precharge),
    .ph_drive     (ph_drive),
    .row_idx      (row_idx),
    .frame_start  (frame_start)
);

// File: tb/dtg_row_timing_tb_top.sv
`timescale 1ns/1ps
module dtg_row_timing_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_on = 1'b0;
    logic [3:0] div_code = '0;
    logic [3:0] dis_len = '0;
    logic [3:0] pre_len = '0;
    logic [7:0] drv_len = '0;
    logic [5:0] mux_last = '0;
    logic       disp_tick, ph_discharge, ph_precharge, ph_drive, frame_start;
    logic [5:0] row_idx;

    always #4 clk = ~clk;

    dtg_row_timing dut_i (
        .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .div_code(div_code),
        .dis_len(dis_len), .pre_len(pre_len), .drv_len(drv_len), .mux_last(mux_last),
        .disp_tick(disp_tick), .ph_discharge(ph_discharge), .ph_precharge(ph_precharge),
        .ph_drive(ph_drive), .row_idx(row_idx), .frame_start(frame_start)
    );

    typedef struct {
        int row;
        int c1;
        int c2;
        int c3;
        int ticks;
        int fs;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- monitor ----------------
    int m_c1 = 0, m_c2 = 0, m_c3 = 0, m_tk = 0, m_row = 0, m_fs = 0;
    bit m_track = 1'b0, prev_dis = 1'b0, prev_drv = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ph_discharge || ph_precharge || ph_drive) begin
                if (ph_discharge && !prev_dis) begin
                    if (prev_drv && m_track) begin
                        if (exp_q.size() == 0) begin
                            chk("R6 unexpected row end", 1, 0);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            chk("R6 row index", m_row, e.row);
                            chk("R7 frame_start at row start", m_fs, e.fs);
                            chk("R4/R5 discharge cycles", m_c1, e.c1);
                            chk("R4/R5 precharge cycles", m_c2, e.c2);
                            chk("R4/R5 drive cycles", m_c3, e.c3);
                            chk("R2 ticks per row", m_tk, e.ticks);
                        end
                    end
                    m_track = 1'b1;
                    m_row = int'(row_idx);
                    m_fs  = int'(frame_start);
                    m_c1 = 0; m_c2 = 0; m_c3 = 0; m_tk = 0;
                end else if (frame_start) begin
                    chk("R7 stray frame_start", 1, 0);
                end
                if (ph_discharge) m_c1++;
                if (ph_precharge) m_c2++;
                if (ph_drive)     m_c3++;
                if (disp_tick)    m_tk++;
            end else begin
                m_track = 1'b0;
            end
            prev_dis = ph_discharge;
            prev_drv = ph_drive;
        end
    end

    // ---------------- driver and reference model ----------------
    int sh_d = 1, sh_p1 = 2, sh_p2 = 2, sh_p3 = 65, sh_mux = 63;  // R1 reset shadows

    task automatic run_test(input int d, input int p1, input int p2, input int p3,
                            input int mux, input int nrows);
        int e_d, e_p1, e_p2, e_p3, row, fs, wrap;
        e_d  = d + 1;
        e_p1 = (p1 == 0) ? 1 : p1;
        e_p2 = (p2 == 0) ? 1 : p2;
        e_p3 = (p3 == 0) ? 1 : p3;
        row = 0;
        fs  = 0;
        for (int i = 0; i < nrows; i++) begin
            exp_q.push_back('{row: row, c1: sh_p1 * sh_d, c2: sh_p2 * sh_d,
                              c3: sh_p3 * sh_d, ticks: sh_p1 + sh_p2 + sh_p3, fs: fs});
            wrap = (row >= sh_mux) ? 1 : 0;
            fs   = wrap;
            row  = wrap ? 0 : row + 1;
            // R8: row-end capture of the held inputs
            sh_d = e_d; sh_p1 = e_p1; sh_p2 = e_p2; sh_p3 = e_p3; sh_mux = mux;
        end
        @(negedge clk);
        div_code = 4'(d); dis_len = 4'(p1); pre_len = 4'(p2);
        drv_len = 8'(p3); mux_last = 6'(mux);
        disp_on = 1'b1;
        @(negedge clk);
        chk("R9 discharge right after enable", int'(ph_discharge), 1);
        chk("R9 row 0 after enable", int'(row_idx), 0);
        while (exp_q.size() != 0) @(negedge clk);
        disp_on = 1'b0;
        @(negedge clk);
        chk("R9 phases off after disable",
            int'(ph_discharge) + int'(ph_precharge) + int'(ph_drive), 0);
        chk("R9 row cleared after disable", int'(row_idx), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 no tick while off", int'(disp_tick), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 phases idle in reset",
            int'(ph_discharge) + int'(ph_precharge) + int'(ph_drive), 0);
        chk("R1 tick low in reset", int'(disp_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 row 0 after reset", int'(row_idx), 0);
        chk("R1 frame_start low after reset", int'(frame_start), 0);
        // R8: first row uses reset defaults, later rows use new inputs
        run_test(1, 3, 4, 5, 3, 6);
        // R5: zero lengths clamp to 1, single-row frame
        run_test(0, 0, 0, 0, 0, 5);
        // R2/R4: maximum division stretches every phase
        run_test(15, 1, 1, 2, 2, 5);
        // R4/R6: widest lengths, two-row frame
        run_test(0, 15, 15, 255, 1, 4);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule